// File: doc/BRIEF.md
# Video frame signature capture

This block computes a 24-bit CRC signature over the pixel stream of a display path so that a test can confirm that a frame reached the output unchanged. It runs in the pixel clock domain, watches a pixel-valid qualifier and the vertical sync line, and folds every qualified pixel word into the signature register while a capture window is open.

Capture is framed by falling edges of vertical sync. Raising the enable arms the block. The next falling edge opens the window. In single-shot mode the following falling edge closes it, the result freezes and a done flag rises. In free-run mode the signature keeps accumulating across frame boundaries. To start a fresh check, software drops the enable, which reloads the seed, and raises it again.

Top module: `vid_sig_capture`

## Requirements
- R1: While `sig_en_i` is 0, `sig_o` is forced to 24'h000001 from the next clock onward, `done_o` is 0, and no pixel changes the signature.
- R2: After `sig_en_i` rises, pixels leave the signature at 24'h000001 until a falling VSYNC edge has been detected.
- R3: Each folded pixel updates the signature with polynomial 24'h864CFB (x^24 implicit). All `PIX_W` data bits are shifted in during one clock, most significant bit first: feedback = sig[23] XOR bit, sig = sig<<1, XOR 24'h864CFB when feedback is 1.
- R4: A clock with `pix_valid_i` at 0 leaves the signature unchanged.
- R5: With `free_run_i` at 0, capture stops at the next falling VSYNC edge after it started, and the signature then holds while `sig_en_i` stays 1.
- R6: `done_o` rises when a single-shot capture ends, stays 1 while `sig_en_i` is 1, and returns to 0 one clock after `sig_en_i` is cleared.
- R7: With `free_run_i` at 1, falling VSYNC edges neither reseed nor stop the capture, and `done_o` stays 0.
- R8: If `free_run_i` is cleared during a running capture, capture stops at the next falling VSYNC edge and `done_o` rises.
- R9: If a low `vsync_i` is first sampled at clock edge k after a high one, an armed capture folds pixels sampled from edge k+3 onward, and a single-shot capture folds its last pixel at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_data_i | input | PIX_W | Pixel data word |
| pix_valid_i | input | 1 | Pixel qualifier, 0 during blanking |
| vsync_i | input | 1 | Vertical sync, asynchronous to the pixel clock |
| sig_en_i | input | 1 | Capture enable; 0 reseeds and holds |
| free_run_i | input | 1 | 1 accumulates across frames, 0 captures one frame |
| sig_o | output | 24 | Current signature |
| done_o | output | 1 | Single-shot capture complete |

## Verification
A wrong capture state shows up at the ports within a few clocks. A window that opens early or late changes `sig_o` on the first qualified pixel, and a window that fails to close keeps `sig_o` moving after the closing edge. A wrong state also raises or drops `done_o` at the wrong edge. An off-by-one in the VSYNC pipeline changes which boundary pixel is folded. Because the CRC diffuses any single-bit difference, that shows as a signature mismatch on the very next folded pixel. The reference model is therefore compared against both outputs on every clock, including around each frame edge.

// File: rtl/vsig_pkg.sv
package vsig_pkg;
  localparam int          SIG_W    = 24;
  localparam logic [23:0] CRC_POLY = 24'h864CFB;
  localparam logic [23:0] CRC_SEED = 24'h000001;

  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/vsig_vsync_sync.sv
module vsig_vsync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], vsync_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/vsig_ctrl.sv
module vsig_ctrl
  import vsig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic free_run_i,
  input  logic fall_i,
  input  logic pix_valid_i,
  output logic fold_o,
  output logic done_o
);
  cap_state_e state_q, state_d;
  logic       close_frame;

  // single-shot window closes on the boundary; that cycle's pixel is not folded
  assign close_frame = fall_i & ~free_run_i;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_ARM;
    end else begin
      unique case (state_q)
        ST_ARM:  if (fall_i)      state_d = ST_RUN;
        ST_RUN:  if (close_frame) state_d = ST_DONE;
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARM;
    else         state_q <= state_d;
  end

  assign fold_o = en_i & (state_q == ST_RUN) & pix_valid_i & ~close_frame;
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/vsig_crc.sv
module vsig_crc
  import vsig_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fold_i,
  input  logic [PIX_W-1:0] data_i,
  output logic [SIG_W-1:0] sig_o
);
  logic [SIG_W-1:0] sig_q, sig_next;

  always_comb begin
    logic fb;
    sig_next = sig_q;
    for (int b = PIX_W - 1; b >= 0; b--) begin
      fb       = sig_next[SIG_W-1] ^ data_i[b];
      sig_next = {sig_next[SIG_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sig_q <= CRC_SEED;
    else if (!en_i)  sig_q <= CRC_SEED;
    else if (fold_i) sig_q <= sig_next;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/vid_sig_capture.sv
module vid_sig_capture
  import vsig_pkg::*;
#(
  parameter int PIX_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_valid_i,
  input  logic             vsync_i,
  input  logic             sig_en_i,
  input  logic             free_run_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             done_o
);
  logic vs_fall;
  logic fold;

  vsig_vsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vsync_i (vsync_i),
    .fall_o  (vs_fall)
  );

  vsig_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (sig_en_i),
    .free_run_i  (free_run_i),
    .fall_i      (vs_fall),
    .pix_valid_i (pix_valid_i),
    .fold_o      (fold),
    .done_o      (done_o)
  );

  vsig_crc #(.PIX_W(PIX_W)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sig_en_i),
    .fold_i (fold),
    .data_i (pix_data_i),
    .sig_o  (sig_o)
  );
endmodule

// File: rtl/vsig_chk.sv
module vsig_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sig_en_i,
  input logic        free_run_i,
  input logic        pix_valid_i,
  input logic [23:0] sig_o,
  input logic        done_o
);
  a_r1_seed_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_en_i |=> (sig_o == 24'h000001) && !done_o);

  a_r4_blank_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_en_i && !pix_valid_i |=> $stable(sig_o));

  a_r5_frozen_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && sig_en_i |=> $stable(sig_o));

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && sig_en_i |=> done_o);

  a_r7_free_run_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_run_i && !done_o |=> !done_o);
endmodule

bind vid_sig_capture vsig_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sig_en_i    (sig_en_i),
  .free_run_i  (free_run_i),
  .pix_valid_i (pix_valid_i),
  .sig_o       (sig_o),
  .done_o      (done_o)
);

// File: tb/vid_sig_capture_tb.sv
`timescale 1ns/1ps
module vid_sig_capture_tb;
  localparam int PW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [PW-1:0] pix = '0;
  logic          valid = 1'b0;
  logic          vs = 1'b1;
  logic          en = 1'b0;
  logic          fr = 1'b0;
  logic [23:0]   sig;
  logic          done;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string req   = "R1";

  always #2 clk_i = ~clk_i;

  vid_sig_capture #(.PIX_W(PW), .SYNC_STAGES(2)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_data_i  (pix),
    .pix_valid_i (valid),
    .vsync_i     (vs),
    .sig_en_i    (en),
    .free_run_i  (fr),
    .sig_o       (sig),
    .done_o      (done)
  );

  // reference model: behavioural, updated at the clock edge
  logic        m_s1, m_s2, m_d, m_f;
  int          m_st;  // 0 armed, 1 running, 2 done
  logic [23:0] m_sig;

  function automatic logic [23:0] ref_crc(input logic [23:0] c, input logic [PW-1:0] d);
    logic [23:0] r = c;
    for (int b = PW - 1; b >= 0; b--) begin
      if (r[23] ^ d[b]) r = (r << 1) ^ 24'h864CFB;
      else              r = r << 1;
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_d = 0; m_st = 0; m_sig = 24'h000001;
    end else begin
      m_f = m_d && !m_s2;
      if (!en) begin
        m_st = 0; m_sig = 24'h000001;
      end else begin
        if (m_st == 1 && valid && !(m_f && !fr)) m_sig = ref_crc(m_sig, pix);
        if (m_st == 0 && m_f) m_st = 1;
        else if (m_st == 1 && m_f && !fr) m_st = 2;
      end
      m_d = m_s2; m_s2 = m_s1; m_s1 = vs;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      n_chk++;
      if (sig !== m_sig || done !== (m_st == 2)) begin
        n_bad++;
        $display("FAIL %s: sig=%h done=%b expected sig=%h done=%b",
                 req, sig, done, m_sig, (m_st == 2));
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 50000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic ck(input string r, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input logic v_s, input logic pv);
    @(negedge clk_i);
    vs = v_s; valid = pv; pix = PW'($urandom);
  endtask

  // sync pulse, then an active region with a given share of blanking
  task automatic frame(input int active, input int blank_mod);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    for (int i = 0; i < active; i++) step(1'b0, (i % blank_mod) != 0);
  endtask

  logic [23:0] held;

  initial begin
    void'($urandom(7));
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    req = "R1";
    step(1'b1, 1'b0);
    ck("R1", sig, 24'h000001);
    ck("R1", {23'b0, done}, 24'h0);
    frame(20, 3);
    ck("R1", sig, 24'h000001);

    req = "R2";
    step(1'b0, 1'b1);
    en = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    ck("R2", sig, 24'h000001);

    req = "R3";
    frame(30, 5);
    n_chk++;
    if (sig === 24'h000001) begin
      n_bad++;
      $display("FAIL R3: actual=%h expected a value other than 000001", sig);
    end

    req = "R4";
    for (int i = 0; i < 12; i++) step(1'b0, (i % 4) == 0);

    req = "R5";
    frame(10, 4);
    held = sig;
    frame(20, 2);
    ck("R5", sig, held);
    ck("R6", {23'b0, done}, 24'h1);

    req = "R6";
    en = 1'b0;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    ck("R6", {23'b0, done}, 24'h0);
    ck("R6", sig, 24'h000001);

    req = "R7";
    en = 1'b1; fr = 1'b1;
    for (int f = 0; f < 3; f++) frame(25, 6);
    ck("R7", {23'b0, done}, 24'h0);

    req = "R8";
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    fr = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    ck("R8", {23'b0, done}, 24'h0);
    frame(8, 3);
    ck("R8", {23'b0, done}, 24'h1);

    req = "R9";
    en = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    en = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    ck("R9", {23'b0, done}, 24'h1);

    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule